// File: doc/BRIEF.md
# Link Width and Lane Reversal Mapper

This block settles the lane layout of a four-lane serial link port once training has gathered its observations. It reads a configured maximum width and a switch that forbids reversed lane order. It also takes a per-physical-lane flag saying a receiving partner answered on that lane, and a flag saying the partner's lane numbering arrived mirrored. On a one-cycle training request it picks the negotiated width (x1, x2 or x4) and a lane order, and registers both.

The registered choice steers a crossbar between logical lanes (the link layer's view) and physical lanes (the pads), in both directions. Physical lanes that carry no logical lane send zero data and drop their activity flag. The legalized maximum width is presented as a 6-bit field of a capability word, for the configuration space to read.

Downshift is not symmetric. Once the link has been running reversed at x4, a later retrain that cannot restore x4 falls back to a single lane and never to x2. A x2 link only ever uses physical lanes 0 and 1, either in normal order or with the two swapped.

Top module: `lmap_top`

## Requirements
- R1: The maximum width input is legal only when it equals 1, 2 or 4; any other value is treated as 1. `lcap_o` carries the legal maximum in bits 11:6 and zero in every other bit.
- R2: `neg_width` is always 1, 2 or 4, and after a training it never exceeds the legal maximum sampled with the request.
- R3: With normal order in force, training gives x4 when the maximum is 4 and all four lanes are detected. Otherwise it gives x2 when the maximum is at least 2 and physical lanes 0 and 1 are both detected. Otherwise it gives x1 on physical lane 0. `reversed` is 0 in each case.
- R4: When reversal is allowed and `far_rev` is 1, a maximum of 4 with all four lanes detected gives x4 reversed: logical lane i uses physical lane 3-i, and `reversed` is 1.
- R5: When reversal is allowed, `far_rev` is 1, x4 is not possible and the previous result was not a reversed x4 or reversed x1 link, a maximum of at least 2 with lanes 0 and 1 detected gives x2 reversed: logical 0 on physical 1 and logical 1 on physical 0. Every other such case gives x1 normal on physical lane 0.
- R6: If the previous result was reversed x4 or reversed x1, and `far_rev` is 1 with reversal allowed, a training that cannot give x4 never gives x2. It gives x1 reversed (logical lane 0 on physical lane 3) when physical lane 3 is detected, and x1 normal on physical lane 0 otherwise.
- R7: When `cfg_rev_dis` is 1, `far_rev` has no effect, and the outcome is the one R3 gives.
- R8: The result is taken on the clock edge that samples `train_req` high. `train_done` is high for exactly the following cycle. Without a request, `neg_width`, `reversed` and `lane_active` hold whatever the inputs do.
- R9: `tx_phy_data` lane p carries logical lane l's transmit data when l is below the width and maps to p; otherwise it is zero and `lane_active[p]` is 0. `rx_log_data` lane l carries the received data of its physical lane when l is below the width, and zero otherwise. Lanes are DW-bit slices, with lane k at bits k*DW and up.
- R10: After reset the link is x1 normal, `lane_active` is 4'b0001, `train_done` is 0 and no reversal history is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_max_width | input | 6 | Configured maximum width (1, 2 or 4) |
| cfg_rev_dis | input | 1 | Forbids reversed lane order when 1 |
| det_lanes | input | 4 | Partner detected on each physical lane |
| far_rev | input | 1 | Partner lane numbering seen mirrored |
| train_req | input | 1 | Take a new width/order decision |
| tx_log_data | input | 4*DW | Transmit data per logical lane |
| rx_phy_data | input | 4*DW | Receive data per physical lane |
| train_done | output | 1 | One-cycle strobe after a decision |
| neg_width | output | 6 | Negotiated width (1, 2 or 4) |
| reversed | output | 1 | Lane order is mirrored |
| lane_active | output | 4 | Physical lane carries a logical lane |
| lcap_o | output | 16 | Capability word, max width at bits 11:6 |
| tx_phy_data | output | 4*DW | Transmit data per physical lane |
| rx_log_data | output | 4*DW | Receive data per logical lane |

## Verification
The assertions assume that the configuration inputs seen at the requesting edge are the ones the decision used. The bench meets this by changing every input only at the falling edge, and it raises `train_req` for exactly one cycle. The assertions place no limit on how often `det_lanes` or `far_rev` change. The bench changes them between trainings, so the hold checks show that an unrequested change moves nothing. The sweep covers legal and illegal maximum values, both reversal settings, both partner orientations and every detection pattern. A directed series first sets up a reversed x4 history and then retrains over all sixteen detection patterns.

// File: rtl/lmap_pkg.sv
package lmap_pkg;
  localparam int LANES = 4;
  localparam int LW    = 6;

  typedef enum logic [1:0] {
    MAP_NORM = 2'd0,
    MAP_REV4 = 2'd1,
    MAP_REV2 = 2'd2,
    MAP_REV1 = 2'd3
  } map_e;

  // Any encoding other than 1, 2 or 4 collapses to a single lane.
  function automatic logic [LW-1:0] legal_width(input logic [LW-1:0] w);
    if (w == LW'(1) || w == LW'(2) || w == LW'(4)) return w;
    return LW'(1);
  endfunction

  // Physical lane that a logical lane uses under a given order.
  function automatic logic [1:0] phys_of(input logic [1:0] l, input map_e m);
    case (m)
      MAP_REV4: return 2'd3 - l;
      MAP_REV2: return {l[1], ~l[0]};
      MAP_REV1: return 2'd3;
      default:  return l;
    endcase
  endfunction

  function automatic logic lane_used(input logic [1:0] l, input logic [LW-1:0] w);
    return {{(LW-2){1'b0}}, l} < w;
  endfunction
endpackage

// File: rtl/lmap_select.sv
module lmap_select
  import lmap_pkg::*;
(
  input  logic [LW-1:0]    max_w,
  input  logic             rev_dis,
  input  logic             far_rev,
  input  logic [LANES-1:0] det,
  input  logic             hist,
  output logic [LW-1:0]    sel_w,
  output map_e             sel_map
);
  logic all_det;
  logic pair_det;
  logic wide_ok;

  assign all_det  = &det;
  assign pair_det = det[0] & det[1];
  assign wide_ok  = (max_w != LW'(1));

  always_comb begin
    sel_w   = LW'(1);
    sel_map = MAP_NORM;
    if (rev_dis || !far_rev) begin
      if (max_w == LW'(4) && all_det)  sel_w = LW'(4);
      else if (wide_ok && pair_det)    sel_w = LW'(2);
    end else if (max_w == LW'(4) && all_det) begin
      sel_w   = LW'(4);
      sel_map = MAP_REV4;
    end else if (hist && det[3]) begin
      sel_map = MAP_REV1;
    end else if (!hist && wide_ok && pair_det) begin
      sel_w   = LW'(2);
      sel_map = MAP_REV2;
    end
  end
endmodule

// File: rtl/lmap_xbar.sv
module lmap_xbar
  import lmap_pkg::*;
#(
  parameter int DW = 8
) (
  input  map_e               map,
  input  logic [LW-1:0]      width,
  input  logic [LANES*DW-1:0] tx_log,
  input  logic [LANES*DW-1:0] rx_phy,
  output logic [LANES*DW-1:0] tx_phy,
  output logic [LANES*DW-1:0] rx_log,
  output logic [LANES-1:0]   active
);
  for (genvar p = 0; p < LANES; p++) begin : g_phys
    always_comb begin
      tx_phy[p*DW +: DW] = '0;
      active[p]          = 1'b0;
      for (int l = 0; l < LANES; l++) begin
        if (lane_used(2'(l), width) && phys_of(2'(l), map) == 2'(p)) begin
          tx_phy[p*DW +: DW] = tx_log[l*DW +: DW];
          active[p]          = 1'b1;
        end
      end
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_log
    logic [1:0] src;
    assign src = phys_of(2'(l), map);
    assign rx_log[l*DW +: DW] = lane_used(2'(l), width) ? rx_phy[int'(src)*DW +: DW] : '0;
  end
endmodule

// File: rtl/lmap_top.sv
module lmap_top
  import lmap_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [5:0]          cfg_max_width,
  input  logic                cfg_rev_dis,
  input  logic [3:0]          det_lanes,
  input  logic                far_rev,
  input  logic                train_req,
  input  logic [4*DW-1:0]     tx_log_data,
  input  logic [4*DW-1:0]     rx_phy_data,
  output logic                train_done,
  output logic [5:0]          neg_width,
  output logic                reversed,
  output logic [3:0]          lane_active,
  output logic [15:0]         lcap_o,
  output logic [4*DW-1:0]     tx_phy_data,
  output logic [4*DW-1:0]     rx_log_data
);
  logic [LW-1:0] max_w_legal;
  logic [LW-1:0] sel_w;
  map_e          sel_map;
  logic [LW-1:0] cur_w;
  map_e          cur_map;
  logic          hist_q;
  logic          hist_next;
  logic          done_q;

  assign max_w_legal = legal_width(cfg_max_width);
  assign lcap_o      = {4'b0000, max_w_legal, 6'b000000};

  lmap_select u_sel (
    .max_w   (max_w_legal),
    .rev_dis (cfg_rev_dis),
    .far_rev (far_rev),
    .det     (det_lanes),
    .hist    (hist_q),
    .sel_w   (sel_w),
    .sel_map (sel_map)
  );

  // History survives only while the link stays in a reversed x4-derived order.
  assign hist_next = (sel_map == MAP_REV4) || (sel_map == MAP_REV1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_w   <= LW'(1);
      cur_map <= MAP_NORM;
      hist_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= train_req;
      if (train_req) begin
        cur_w   <= sel_w;
        cur_map <= sel_map;
        hist_q  <= hist_next;
      end
    end
  end

  lmap_xbar #(.DW(DW)) u_xbar (
    .map    (cur_map),
    .width  (cur_w),
    .tx_log (tx_log_data),
    .rx_phy (rx_phy_data),
    .tx_phy (tx_phy_data),
    .rx_log (rx_log_data),
    .active (lane_active)
  );

  assign train_done = done_q;
  assign neg_width  = cur_w;
  assign reversed   = (cur_map != MAP_NORM);
endmodule

// File: rtl/lmap_chk.sv
module lmap_chk #(
  parameter int DW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_rev_dis,
  input logic            train_req,
  input logic            train_done,
  input logic [5:0]      neg_width,
  input logic            reversed,
  input logic [3:0]      lane_active,
  input logic [15:0]     lcap_o,
  input logic [4*DW-1:0] tx_phy_data
);
  assert_legal_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (neg_width == 6'd1) || (neg_width == 6'd2) || (neg_width == 6'd4));

  assert_width_capped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    train_done |-> neg_width <= $past(lcap_o[11:6]));

  assert_lcap_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (lcap_o[15:12] == 4'd0) && (lcap_o[5:0] == 6'd0));

  assert_no_rev_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    train_done && $past(cfg_rev_dis) |-> !reversed);

  assert_no_x2_after_rev4_R6: assert property (@(posedge clk) disable iff (!rst_n)
    train_done && $past(reversed && neg_width == 6'd4) |-> !(reversed && neg_width == 6'd2));

  assert_done_follows_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    train_req |=> train_done);

  assert_hold_without_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !train_req |=> !train_done && $stable(neg_width) && $stable(reversed) && $stable(lane_active));

  assert_active_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lane_active) == int'(neg_width));

  for (genvar p = 0; p < 4; p++) begin : g_idle
    assert_idle_lane_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !lane_active[p] |-> tx_phy_data[p*DW +: DW] == '0);
  end
endmodule

bind lmap_top lmap_chk #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_rev_dis (cfg_rev_dis),
  .train_req   (train_req),
  .train_done  (train_done),
  .neg_width   (neg_width),
  .reversed    (reversed),
  .lane_active (lane_active),
  .lcap_o      (lcap_o),
  .tx_phy_data (tx_phy_data)
);

// File: tb/tb_lmap_top.sv
`timescale 1ns/1ps
module tb_lmap_top;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [5:0]    cfg_max_width = 6'd4;
  logic          cfg_rev_dis = 1'b0;
  logic [3:0]    det_lanes = 4'd0;
  logic          far_rev = 1'b0;
  logic          train_req = 1'b0;
  logic [4*DW-1:0] tx_log_data = '0;
  logic [4*DW-1:0] rx_phy_data = '0;
  logic          train_done;
  logic [5:0]    neg_width;
  logic          reversed;
  logic [3:0]    lane_active;
  logic [15:0]   lcap_o;
  logic [4*DW-1:0] tx_phy_data;
  logic [4*DW-1:0] rx_log_data;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  bit m_hist = 1'b0;
  int seed_ctr = 0;

  always #10 clk = ~clk;

  lmap_top #(.DW(DW)) dut (.*);

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Bench model: returns width, order code (0 normal, 1 rev4, 2 rev2, 3 rev1) and rule tag.
  task automatic model(input int cw, input bit rd, input bit fr, input int det,
                       output int w, output int mode, output string tag);
    int mx;
    bit d0, d1, d3;
    mx = (cw == 1 || cw == 2 || cw == 4) ? cw : 1;
    d0 = det[0]; d1 = det[1]; d3 = det[3];
    w = 1; mode = 0;
    if (rd || !fr) begin
      tag = (rd && fr) ? "R7" : "R3";
      if (mx == 4 && det == 15) w = 4;
      else if (mx >= 2 && d0 && d1) w = 2;
    end else if (mx == 4 && det == 15) begin
      tag = "R4"; w = 4; mode = 1;
    end else if (m_hist) begin
      tag = "R6";
      if (d3) mode = 3;
    end else begin
      tag = "R5";
      if (mx >= 2 && d0 && d1) begin w = 2; mode = 2; end
    end
  endtask

  function automatic int bphys(input int l, input int mode);
    case (mode)
      1: return 3 - l;
      2: return 1 - l;
      3: return 3;
      default: return l;
    endcase
  endfunction

  task automatic check_data(input int w, input int mode, input string tag);
    logic [4*DW-1:0] exp_tx, exp_rx;
    int exp_act;
    seed_ctr++;
    for (int k = 0; k < 4; k++) begin
      tx_log_data[k*DW +: DW] = DW'((seed_ctr * 37 + k * 11 + 1) & 8'hFF);
      rx_phy_data[k*DW +: DW] = DW'((seed_ctr * 53 + k * 29 + 7) & 8'hFF);
    end
    #1;
    exp_tx = '0; exp_rx = '0; exp_act = 0;
    for (int l = 0; l < w; l++) begin
      exp_tx[bphys(l, mode)*DW +: DW] = tx_log_data[l*DW +: DW];
      exp_rx[l*DW +: DW] = rx_phy_data[bphys(l, mode)*DW +: DW];
      exp_act = exp_act | (1 << bphys(l, mode));
    end
    check(tx_phy_data == exp_tx, {"R9 tx crossbar ", tag}, tx_phy_data, exp_tx);
    check(rx_log_data == exp_rx, {"R9 rx crossbar ", tag}, rx_log_data, exp_rx);
    check(lane_active == 4'(exp_act), {"R9 active ", tag}, lane_active, exp_act);
  endtask

  task automatic do_train(input int cw, input bit rd, input bit fr, input int det);
    int w, mode, mx;
    string tag;
    model(cw, rd, fr, det, w, mode, tag);
    mx = (cw == 1 || cw == 2 || cw == 4) ? cw : 1;
    cfg_max_width = 6'(cw); cfg_rev_dis = rd; far_rev = fr; det_lanes = 4'(det);
    train_req = 1'b1;
    #1;
    check(lcap_o == 16'(mx << 6), "R1 capability field", lcap_o, mx << 6);
    @(negedge clk);
    train_req = 1'b0;
    m_hist = (mode == 1) || (mode == 3);
    check(train_done == 1'b1, "R8 done strobe", train_done, 1);
    check(int'(neg_width) == w, {"width ", tag}, neg_width, w);
    check(reversed == (mode != 0), {"order ", tag}, reversed, mode != 0);
    check(int'(neg_width) <= mx, "R2 width within max", neg_width, mx);
    check_data(w, mode, tag);
    // Inputs move without a request: nothing registered may change.
    det_lanes = ~det_lanes; far_rev = ~far_rev; cfg_max_width = 6'd2;
    @(negedge clk);
    check(train_done == 1'b0, "R8 strobe single", train_done, 0);
    check(int'(neg_width) == w && reversed == (mode != 0), "R8 hold", neg_width, w);
  endtask

  initial begin
    int cws[8] = '{0, 1, 2, 3, 4, 5, 8, 63};
    repeat (3) @(negedge clk);
    check(train_done == 1'b0, "R10 reset strobe", train_done, 0);
    check(neg_width == 6'd1, "R10 reset width", neg_width, 1);
    check(lane_active == 4'b0001, "R10 reset lanes", lane_active, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(reversed == 1'b0, "R10 reset order", reversed, 0);
    check_data(1, 0, "R10");
    foreach (cws[i]) begin
      for (int rd = 0; rd < 2; rd++)
        for (int fr = 0; fr < 2; fr++)
          for (int det = 0; det < 16; det++)
            do_train(cws[i], 1'(rd), 1'(fr), det);
    end
    // Reversed x4 history followed by every detection pattern (R6).
    for (int det = 0; det < 16; det++) begin
      do_train(4, 1'b0, 1'b1, 15);
      do_train(det[0] ? 4 : 2, 1'b0, 1'b1, det);
      do_train(2, 1'b0, 1'b1, det);
    end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule